// File: doc/BRIEF.md
# Pipelined Add-Compare-Select Butterfly

This block performs one radix-2 add-compare-select step of a trellis decoder. Each cycle it can take the old path metrics of two predecessor states and the four branch metrics that link them to two successor states. For each successor it forms two candidate sums, each a predecessor metric plus the branch metric on that transition. It keeps the smaller sum as the new metric and reports which candidate won as a decision bit.

Register stages sit after the adders, after the comparators and at the outputs. This shortens the critical path, so one unit can be time-shared over many states at a higher clock rate. A valid flag moves through the stages beside the data. A scheduler may therefore issue an independent butterfly on every cycle while earlier ones are still in flight. State scheduling and metric storage are handled outside the block.

Top module: `acs_butterfly_pipe`

## Requirements
- R1: For each successor state, the output metric equals the smaller of its two candidate sums. For successor 0 the first candidate is `pm_a + bm_a0` and the second is `pm_b + bm_b0`. For successor 1 they are `pm_a + bm_a1` and `pm_b + bm_b1`.
- R2: A decision bit is 1 exactly when the second candidate (the one through `pm_b`) is strictly smaller than the first. The output metric is the candidate that the decision bit names.
- R3: When the two candidate sums are equal, the decision bit is 0 and the output metric is the first candidate.
- R4: A candidate sum that would exceed the largest metric value (1023 for 10-bit metrics) is clamped to that value instead of wrapping.
- R5: Results appear at the outputs on the third rising edge, counting the edge that samples the inputs as the first. `out_valid` is the value `in_valid` had at that sampling edge, so `out_valid` is low whenever no operation was issued.
- R6: Operations issued on consecutive cycles are independent. Each one produces its own result, in issue order, one per cycle.
- R7: While `rst_n` is low, `out_valid`, both output metrics and both decision bits are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies the input operands in this cycle |
| pm_a | input | MW | Old metric of the first predecessor state |
| pm_b | input | MW | Old metric of the second predecessor state |
| bm_a0 | input | BW | Branch metric from the first predecessor to successor 0 |
| bm_b0 | input | BW | Branch metric from the second predecessor to successor 0 |
| bm_a1 | input | BW | Branch metric from the first predecessor to successor 1 |
| bm_b1 | input | BW | Branch metric from the second predecessor to successor 1 |
| out_valid | output | 1 | Qualifies the result outputs |
| pm_new0 | output | MW | Updated metric of successor 0 |
| pm_new1 | output | MW | Updated metric of successor 1 |
| dec0 | output | 1 | Decision bit for successor 0 (1 = second predecessor won) |
| dec1 | output | 1 | Decision bit for successor 1 (1 = second predecessor won) |

## Verification
Every result (both metrics, both decisions and `out_valid`) is due on the third rising edge, counting the edge that samples the operands as the first. The bench drives operands on falling edges. It samples the outputs on the falling edge three cycles after the one where the operands went in, so each back-to-back vector is checked exactly when its own result is present. A lone operation is also tracked cycle by cycle, to confirm that `out_valid` is low on the two cycles before the result and on the cycle after it. The checker compares the outputs with the inputs from three edges earlier and only starts once three edges have passed outside reset.

// File: rtl/acs_butterfly_pipe.sv
module acs_butterfly_pipe #(
  parameter int MW = 10,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [MW-1:0] pm_a,
  input  logic [MW-1:0] pm_b,
  input  logic [BW-1:0] bm_a0,
  input  logic [BW-1:0] bm_b0,
  input  logic [BW-1:0] bm_a1,
  input  logic [BW-1:0] bm_b1,
  output logic          out_valid,
  output logic [MW-1:0] pm_new0,
  output logic [MW-1:0] pm_new1,
  output logic          dec0,
  output logic          dec1
);
  localparam int EXT = MW + 1 - BW;

  function automatic logic [MW-1:0] sat_add(input logic [MW-1:0] p, input logic [BW-1:0] b);
    logic [MW:0] s;
    s = {1'b0, p} + {{EXT{1'b0}}, b};
    return s[MW] ? {MW{1'b1}} : s[MW-1:0];
  endfunction

  logic          v1, v2;
  logic [MW-1:0] c_a0, c_b0, c_a1, c_b1;
  logic [MW-1:0] q_a0, q_b0, q_a1, q_b1;
  logic          k0, k1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      c_a0 <= '0; c_b0 <= '0; c_a1 <= '0; c_b1 <= '0;
    end else begin
      v1   <= in_valid;
      c_a0 <= sat_add(pm_a, bm_a0);
      c_b0 <= sat_add(pm_b, bm_b0);
      c_a1 <= sat_add(pm_a, bm_a1);
      c_b1 <= sat_add(pm_b, bm_b1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0;
      q_a0 <= '0; q_b0 <= '0; q_a1 <= '0; q_b1 <= '0;
      k0 <= 1'b0; k1 <= 1'b0;
    end else begin
      v2   <= v1;
      q_a0 <= c_a0; q_b0 <= c_b0;
      q_a1 <= c_a1; q_b1 <= c_b1;
      k0   <= c_b0 < c_a0;
      k1   <= c_b1 < c_a1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pm_new0 <= '0; pm_new1 <= '0;
      dec0 <= 1'b0; dec1 <= 1'b0;
    end else begin
      out_valid <= v2;
      pm_new0   <= k0 ? q_b0 : q_a0;
      pm_new1   <= k1 ? q_b1 : q_a1;
      dec0      <= k0;
      dec1      <= k1;
    end
  end
endmodule

// File: rtl/acs_butterfly_pipe_chk.sv
module acs_butterfly_pipe_chk #(
  parameter int MW = 10,
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [MW-1:0] pm_a,
  input logic [MW-1:0] pm_b,
  input logic [BW-1:0] bm_a0,
  input logic [BW-1:0] bm_b0,
  input logic [BW-1:0] bm_a1,
  input logic [BW-1:0] bm_b1,
  input logic          out_valid,
  input logic [MW-1:0] pm_new0,
  input logic [MW-1:0] pm_new1,
  input logic          dec0,
  input logic          dec1
);
  function automatic logic [MW-1:0] cand(input logic [MW-1:0] p, input logic [BW-1:0] b);
    logic [MW:0] s;
    s = {1'b0, p} + {{(MW+1-BW){1'b0}}, b};
    return s[MW] ? {MW{1'b1}} : s[MW-1:0];
  endfunction

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  logic ready;
  assign ready = (age == 2'd3);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (out_valid == $past(in_valid, 3))); // R5

  AST_MIN_NEW0: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && out_valid) |-> (pm_new0 <= cand($past(pm_a,3), $past(bm_a0,3)) &&
                              pm_new0 <= cand($past(pm_b,3), $past(bm_b0,3)))); // R1

  AST_MIN_NEW1: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && out_valid) |-> (pm_new1 <= cand($past(pm_a,3), $past(bm_a1,3)) &&
                              pm_new1 <= cand($past(pm_b,3), $past(bm_b1,3)))); // R1

  AST_DEC0_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && out_valid) |-> (pm_new0 == (dec0 ? cand($past(pm_b,3), $past(bm_b0,3))
                                               : cand($past(pm_a,3), $past(bm_a0,3))))); // R2

  AST_DEC1_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && out_valid) |-> (pm_new1 == (dec1 ? cand($past(pm_b,3), $past(bm_b1,3))
                                               : cand($past(pm_a,3), $past(bm_a1,3))))); // R2

  AST_TIE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && out_valid && cand($past(pm_a,3), $past(bm_a0,3)) == cand($past(pm_b,3), $past(bm_b0,3)))
      |-> !dec0); // R3

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && out_valid && !dec0) |-> (pm_new0 >= $past(pm_a,3))); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && pm_new0 == '0 && pm_new1 == '0 && !dec0 && !dec1)); // R7
endmodule

bind acs_butterfly_pipe acs_butterfly_pipe_chk #(.MW(MW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pm_a(pm_a), .pm_b(pm_b),
  .bm_a0(bm_a0), .bm_b0(bm_b0), .bm_a1(bm_a1), .bm_b1(bm_b1),
  .out_valid(out_valid), .pm_new0(pm_new0), .pm_new1(pm_new1),
  .dec0(dec0), .dec1(dec1)
);

// File: tb/acs_butterfly_pipe_test.sv
module acs_butterfly_pipe_test;
  localparam int MW = 10;
  localparam int BW = 4;
  localparam int NV = 8;

  // operands: pm_a, pm_b, bm_a0, bm_b0, bm_a1, bm_b1 ; expected: new0, dec0, new1, dec1
  localparam logic [MW-1:0] T_PA [NV] = '{10'd100, 10'd300, 10'd10, 10'd1020, 10'd1023, 10'd0, 10'd0, 10'd512};
  localparam logic [MW-1:0] T_PB [NV] = '{10'd200, 10'd50,  10'd12, 10'd1023, 10'd1010, 10'd0, 10'd1, 10'd511};
  localparam logic [BW-1:0] T_A0 [NV] = '{4'd3, 4'd2,  4'd4, 4'd15, 4'd1,  4'd0, 4'd2, 4'd0};
  localparam logic [BW-1:0] T_B0 [NV] = '{4'd5, 4'd15, 4'd2, 4'd15, 4'd9,  4'd0, 4'd0, 4'd0};
  localparam logic [BW-1:0] T_A1 [NV] = '{4'd7, 4'd0,  4'd5, 4'd2,  4'd9,  4'd0, 4'd1, 4'd15};
  localparam logic [BW-1:0] T_B1 [NV] = '{4'd1, 4'd0,  4'd3, 4'd0,  4'd13, 4'd0, 4'd1, 4'd15};
  localparam logic [MW-1:0] X_N0 [NV] = '{10'd103, 10'd65, 10'd14, 10'd1023, 10'd1019, 10'd0, 10'd1, 10'd511};
  localparam logic          X_D0 [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [MW-1:0] X_N1 [NV] = '{10'd107, 10'd50, 10'd15, 10'd1022, 10'd1023, 10'd0, 10'd1, 10'd526};
  localparam logic          X_D1 [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam string         X_TAG [NV] = '{"R1", "R2", "R3", "R4", "R4", "R3", "R2", "R4"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [MW-1:0] pm_a = '0, pm_b = '0;
  logic [BW-1:0] bm_a0 = '0, bm_b0 = '0, bm_a1 = '0, bm_b1 = '0;
  logic out_valid, dec0, dec1;
  logic [MW-1:0] pm_new0, pm_new1;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  acs_butterfly_pipe #(.MW(MW), .BW(BW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pm_a(pm_a), .pm_b(pm_b),
    .bm_a0(bm_a0), .bm_b0(bm_b0), .bm_a1(bm_a1), .bm_b1(bm_b1),
    .out_valid(out_valid), .pm_new0(pm_new0), .pm_new1(pm_new1),
    .dec0(dec0), .dec1(dec1)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input int i);
    in_valid = 1'b1;
    pm_a = T_PA[i]; pm_b = T_PB[i];
    bm_a0 = T_A0[i]; bm_b0 = T_B0[i]; bm_a1 = T_A1[i]; bm_b1 = T_B1[i];
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    in_valid = 1'b1;
    pm_a = 10'd7; bm_a0 = 4'd3;
    repeat (3) @(negedge clk);
    chk("R7", "out_valid in reset", int'(out_valid), 0);
    chk("R7", "pm_new0 in reset", int'(pm_new0), 0);
    chk("R7", "dec pair in reset", int'({dec0, dec1}), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    // back-to-back table walk: R6
    for (int j = 0; j < NV + 3; j++) begin
      @(negedge clk);
      if (j >= 3) begin
        chk("R6", "out_valid", int'(out_valid), 1);
        chk(X_TAG[j-3], "pm_new0", int'(pm_new0), int'(X_N0[j-3]));
        chk(X_TAG[j-3], "dec0", int'(dec0), int'(X_D0[j-3]));
        chk(X_TAG[j-3], "pm_new1", int'(pm_new1), int'(X_N1[j-3]));
        chk(X_TAG[j-3], "dec1", int'(dec1), int'(X_D1[j-3]));
      end
      if (j < NV) drive(j);
      else in_valid = 1'b0;
    end
    @(negedge clk);
    chk("R5", "out_valid after stream", int'(out_valid), 0);

    // lone operation latency: R5
    repeat (2) @(negedge clk);
    drive(1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5", "out_valid edge1", int'(out_valid), 0);
    @(negedge clk);
    chk("R5", "out_valid edge2", int'(out_valid), 0);
    @(negedge clk);
    chk("R5", "out_valid edge3", int'(out_valid), 1);
    chk("R5", "pm_new0 edge3", int'(pm_new0), 65);
    @(negedge clk);
    chk("R5", "out_valid edge4", int'(out_valid), 0);

    // reset in flight: R7
    drive(7);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7", "flushed out_valid", int'(out_valid), 0);
    @(negedge clk);
    chk("R7", "flushed out_valid later", int'(out_valid), 0);
    chk("R7", "flushed pm_new1", int'(pm_new1), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule